// File: doc/BRIEF.md
# Shadowed Multi-Master Instruction RAM Access Controller

This block sits between several bus masters and the instruction store of a timer engine. Each instruction slot holds three 32-bit words: a program word, a control word and a data word. Masters carry an ID and issue single-cycle requests. A request is a read of 8, 16 or 32 bits, or a write of 32 bits. A registered response follows one cycle later. It carries a valid flag, an error flag and the read data.

A read of a control word also snapshots the matching data word into a shadow slot owned by that master. The same master's following data read of that instruction is then served from the snapshot, so the pair behaves as one atomic 64-bit read. A small pool of shadow slots lets several masters interleave such pairs. A master that cannot get a slot is refused with an error.

The data word can be set to clear itself when the host reads it. A capture from the timer engine landing on that word in the same cycle takes precedence over the clear.

Top module: `hostram_ctrl`

## Requirements
- R1: Every request accepted on a rising edge produces exactly one response, with resp_valid high on the following cycle only; resp_valid is low after reset.
- R2: Field code 0 is the program word, 1 the control word and 2 the data word. Size code 0 returns the low 8 bits zero-extended, 1 the low 16 bits, 2 all 32 bits. Field code 3 or size code 3 yields an error.
- R3: A write with size code 2 stores write data into the addressed word. A write with size code 0 or 1 yields an error and leaves storage unchanged.
- R4: A control-word read by a master copies the data word of that instruction, as stored before that cycle, into that master's shadow slot. That master's next data read of the same instruction returns the copy and frees the slot.
- R5: A master holds at most one shadow slot. A new control-word read by a master that already owns a slot reuses it.
- R6: Free slots are taken lowest index first. With three slots, three masters may interleave their control and data reads, and a freed slot is available again.
- R7: With all slots held, a control or data read by a master that owns none yields an error and has no side effect on storage or slots.
- R8: Program-word reads and all writes succeed regardless of slot occupancy.
- R9: When bit 26 of an instruction's control word is set, a direct data read returns the stored value and then clears the data word.
- R10: The clear of R9 also applies when the data read is served from a shadow slot.
- R11: A capture from the timer engine always updates its data word. If it targets the word being cleared in the same cycle, the capture value remains and the clear is dropped.
- R12: An error response carries all-zero read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_mid | input | MID_W | Requesting master ID |
| req_idx | input | IDX_W | Instruction index |
| req_field | input | 2 | Word select: 0 program, 1 control, 2 data |
| req_size | input | 2 | Access size: 0 byte, 1 half, 2 word |
| req_wdata | input | 32 | Write data |
| cap_valid | input | 1 | Timer engine capture strobe |
| cap_idx | input | IDX_W | Capture target instruction |
| cap_data | input | 32 | Capture value |
| resp_valid | output | 1 | Response strobe |
| resp_err | output | 1 | Error response |
| resp_rdata | output | 32 | Read data, zero on error |

## Verification
The bench builds the block with IDX_W=2 and MID_W=2. That gives four instructions and four masters. Every field, index and size combination can therefore be swept with computed word patterns. Four masters against three slots make slot exhaustion, refusal of the fourth master, slot reuse and release all reachable in short sequences. The small index space also lets same-index and different-index capture collisions with the clear be set up directly.

// File: rtl/hostram_pkg.sv
package hostram_pkg;
  localparam int HR_DW = 32;

  typedef enum logic [1:0] {
    FLD_PRG = 2'd0,
    FLD_CTL = 2'd1,
    FLD_DAT = 2'd2,
    FLD_BAD = 2'd3
  } fld_e;

  typedef enum logic [1:0] {
    SZ_B8  = 2'd0,
    SZ_B16 = 2'd1,
    SZ_W32 = 2'd2,
    SZ_BAD = 2'd3
  } size_e;

  function automatic logic [HR_DW-1:0] size_mask(input logic [HR_DW-1:0] v, input logic [1:0] sz);
    case (sz)
      SZ_B8:   size_mask = {{(HR_DW-8){1'b0}}, v[7:0]};
      SZ_B16:  size_mask = {{(HR_DW-16){1'b0}}, v[15:0]};
      default: size_mask = v;
    endcase
  endfunction
endpackage

// File: rtl/hostram_field_ram.sv
module hostram_field_ram #(
  parameter int AW = 3,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/hostram_shadow_pool.sv
module hostram_shadow_pool #(
  parameter int N_SHD  = 3,
  parameter int MID_W  = 2,
  parameter int IDX_W  = 3,
  parameter int DATA_W = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [MID_W-1:0]         lk_mid,
  input  logic [IDX_W-1:0]         lk_idx,
  output logic                     own_hit,
  output logic                     exact_hit,
  output logic                     free_any,
  output logic [DATA_W-1:0]        sh_data,
  input  logic                     load,
  input  logic [DATA_W-1:0]        load_data,
  input  logic                     rel,
  output logic [N_SHD-1:0]         vld_o,
  output logic [N_SHD*MID_W-1:0]   mid_o
);
  localparam int SW = (N_SHD > 1) ? $clog2(N_SHD) : 1;

  logic [N_SHD-1:0]  vld_q;
  logic [MID_W-1:0]  mid_q  [N_SHD];
  logic [IDX_W-1:0]  idx_q  [N_SHD];
  logic [DATA_W-1:0] dat_q  [N_SHD];
  logic [SW-1:0]     own_slot, free_slot, sel_slot;

  always_comb begin
    own_hit   = 1'b0;
    own_slot  = '0;
    free_any  = 1'b0;
    free_slot = '0;
    for (int s = N_SHD-1; s >= 0; s--) begin
      if (!vld_q[s]) begin
        free_any  = 1'b1;
        free_slot = SW'(s);
      end
      if (vld_q[s] && mid_q[s] == lk_mid) begin
        own_hit  = 1'b1;
        own_slot = SW'(s);
      end
    end
    sel_slot  = own_hit ? own_slot : free_slot;
    exact_hit = own_hit && (idx_q[own_slot] == lk_idx);
    sh_data   = dat_q[own_slot];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
      for (int s = 0; s < N_SHD; s++) begin
        mid_q[s] <= '0;
        idx_q[s] <= '0;
        dat_q[s] <= '0;
      end
    end else if (load && (own_hit || free_any)) begin
      vld_q[sel_slot] <= 1'b1;
      mid_q[sel_slot] <= lk_mid;
      idx_q[sel_slot] <= lk_idx;
      dat_q[sel_slot] <= load_data;
    end else if (rel && exact_hit) begin
      vld_q[own_slot] <= 1'b0;
    end
  end

  generate
    for (genvar s = 0; s < N_SHD; s++) begin : g_out
      assign mid_o[s*MID_W +: MID_W] = mid_q[s];
    end
  endgenerate
  assign vld_o = vld_q;
endmodule

// File: rtl/hostram_ctrl.sv
module hostram_ctrl
  import hostram_pkg::*;
#(
  parameter int IDX_W   = 3,
  parameter int MID_W   = 2,
  parameter int N_SHD   = 3,
  parameter int CLR_BIT = 26
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_we,
  input  logic [MID_W-1:0] req_mid,
  input  logic [IDX_W-1:0] req_idx,
  input  logic [1:0]       req_field,
  input  logic [1:0]       req_size,
  input  logic [31:0]      req_wdata,
  input  logic             cap_valid,
  input  logic [IDX_W-1:0] cap_idx,
  input  logic [31:0]      cap_data,
  output logic             resp_valid,
  output logic             resp_err,
  output logic [31:0]      resp_rdata
);
  localparam int N_INS = 1 << IDX_W;

  logic [HR_DW-1:0] ram_rd [2];
  logic [HR_DW-1:0] df_q [N_INS];
  logic [HR_DW-1:0] df_rd, rd_val, sh_data;
  logic             own_hit, exact_hit, free_any;
  logic             acc_err, wr_ok, sh_load, sh_rel, df_clr;
  logic [N_SHD-1:0]       sh_vld;
  logic [N_SHD*MID_W-1:0] sh_mid;
  fld_e             fld;

  assign fld   = fld_e'(req_field);
  assign df_rd = df_q[req_idx];

  // program and control words: one RAM each
  generate
    for (genvar f = 0; f < 2; f++) begin : g_ram
      hostram_field_ram #(.AW(IDX_W), .DW(HR_DW)) u_ram (
        .clk   (clk),
        .we    (wr_ok && req_field == 2'(f)),
        .waddr (req_idx),
        .wdata (req_wdata),
        .raddr (req_idx),
        .rdata (ram_rd[f])
      );
    end
  endgenerate

  hostram_shadow_pool #(.N_SHD(N_SHD), .MID_W(MID_W), .IDX_W(IDX_W), .DATA_W(HR_DW)) u_pool (
    .clk       (clk),
    .rst       (rst),
    .lk_mid    (req_mid),
    .lk_idx    (req_idx),
    .own_hit   (own_hit),
    .exact_hit (exact_hit),
    .free_any  (free_any),
    .sh_data   (sh_data),
    .load      (sh_load),
    .load_data (df_rd),
    .rel       (sh_rel),
    .vld_o     (sh_vld),
    .mid_o     (sh_mid)
  );

  always_comb begin
    acc_err = 1'b0;
    wr_ok   = 1'b0;
    sh_load = 1'b0;
    sh_rel  = 1'b0;
    df_clr  = 1'b0;
    rd_val  = '0;
    if (req_valid) begin
      if (fld == FLD_BAD || size_e'(req_size) == SZ_BAD) begin
        acc_err = 1'b1;
      end else if (req_we) begin
        if (size_e'(req_size) != SZ_W32) acc_err = 1'b1;
        else                             wr_ok   = 1'b1;
      end else begin
        case (fld)
          FLD_PRG: rd_val = ram_rd[0];
          FLD_CTL: begin
            if (own_hit || free_any) begin
              rd_val  = ram_rd[1];
              sh_load = 1'b1;
            end else begin
              acc_err = 1'b1;
            end
          end
          default: begin
            if (exact_hit) begin
              rd_val = sh_data;
              sh_rel = 1'b1;
              df_clr = ram_rd[1][CLR_BIT];
            end else if (!own_hit && !free_any) begin
              acc_err = 1'b1;
            end else begin
              rd_val = df_rd;
              df_clr = ram_rd[1][CLR_BIT];
            end
          end
        endcase
      end
    end
  end

  // data words: capture first, then host write, then read-clear
  always_ff @(posedge clk) begin
    for (int i = 0; i < N_INS; i++) begin
      if (rst)
        df_q[i] <= '0;
      else if (cap_valid && cap_idx == IDX_W'(i))
        df_q[i] <= cap_data;
      else if (wr_ok && fld == FLD_DAT && req_idx == IDX_W'(i))
        df_q[i] <= req_wdata;
      else if (df_clr && req_idx == IDX_W'(i))
        df_q[i] <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid <= 1'b0;
      resp_err   <= 1'b0;
      resp_rdata <= '0;
    end else begin
      resp_valid <= req_valid;
      resp_err   <= req_valid && acc_err;
      resp_rdata <= (req_valid && !acc_err) ? size_mask(rd_val, req_size) : '0;
    end
  end
endmodule

// File: rtl/hostram_chk.sv
module hostram_chk #(
  parameter int MID_W = 2,
  parameter int N_SHD = 3
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   req_valid,
  input logic                   req_we,
  input logic [1:0]             req_field,
  input logic [1:0]             req_size,
  input logic                   resp_valid,
  input logic                   resp_err,
  input logic [31:0]            resp_rdata,
  input logic [N_SHD-1:0]       sh_vld,
  input logic [N_SHD*MID_W-1:0] sh_mid
);
  a_r1_resp_follows: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> resp_valid);
  a_r1_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !resp_valid);
  a_r3_narrow_write_err: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_we && req_size != 2'd2) |=> resp_err);
  a_r8_prog_read_ok: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_we && req_field == 2'd0 && req_size != 2'd3) |=> (resp_valid && !resp_err));
  a_r8_write_ok: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_we && req_field != 2'd3 && req_size == 2'd2) |=> (resp_valid && !resp_err));
  a_r12_err_zero: assert property (@(posedge clk) disable iff (rst)
    resp_err |-> (resp_valid && resp_rdata == 32'd0));

  generate
    for (genvar a = 0; a < N_SHD; a++) begin : g_a
      for (genvar b = a + 1; b < N_SHD; b++) begin : g_b
        a_r5_one_slot_per_master: assert property (@(posedge clk) disable iff (rst)
          (sh_vld[a] && sh_vld[b]) |-> (sh_mid[a*MID_W +: MID_W] != sh_mid[b*MID_W +: MID_W]));
      end
    end
  endgenerate
endmodule

bind hostram_ctrl hostram_chk #(.MID_W(MID_W), .N_SHD(N_SHD)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_we     (req_we),
  .req_field  (req_field),
  .req_size   (req_size),
  .resp_valid (resp_valid),
  .resp_err   (resp_err),
  .resp_rdata (resp_rdata),
  .sh_vld     (sh_vld),
  .sh_mid     (sh_mid)
);

// File: tb/hostram_ctrl_tb_top.sv
module hostram_ctrl_tb_top;
  localparam int IDX_W = 2;
  localparam int MID_W = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_we = 1'b0;
  logic [MID_W-1:0] req_mid = '0;
  logic [IDX_W-1:0] req_idx = '0;
  logic [1:0] req_field = '0, req_size = '0;
  logic [31:0] req_wdata = '0;
  logic cap_valid = 1'b0;
  logic [IDX_W-1:0] cap_idx = '0;
  logic [31:0] cap_data = '0;
  logic resp_valid, resp_err;
  logic [31:0] resp_rdata;

  int n_run = 0, n_fail = 0, cyc = 0;
  logic g_vld, g_err;
  logic [31:0] g_dat;

  always #10 clk = ~clk;

  hostram_ctrl #(.IDX_W(IDX_W), .MID_W(MID_W), .N_SHD(3), .CLR_BIT(26)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_we(req_we), .req_mid(req_mid),
    .req_idx(req_idx), .req_field(req_field), .req_size(req_size), .req_wdata(req_wdata),
    .cap_valid(cap_valid), .cap_idx(cap_idx), .cap_data(cap_data),
    .resp_valid(resp_valid), .resp_err(resp_err), .resp_rdata(resp_rdata));

  function automatic logic [31:0] pat(input int f, input int i);
    pat = 32'hA000_0000 | (32'(f) << 20) | (32'(i) << 8) | (32'h5A ^ 32'(i * 3 + f));
  endfunction

  function automatic logic [31:0] msk(input logic [31:0] v, input int sz);
    msk = (sz == 0) ? (v & 32'hFF) : (sz == 1) ? (v & 32'hFFFF) : v;
  endfunction

  task automatic xfer(input logic we, input int mid, input int idx, input int fld, input int sz,
                      input logic [31:0] wd, input logic cv, input int ci, input logic [31:0] cd);
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_mid = MID_W'(mid); req_idx = IDX_W'(idx);
    req_field = 2'(fld); req_size = 2'(sz); req_wdata = wd;
    cap_valid = cv; cap_idx = IDX_W'(ci); cap_data = cd;
    @(negedge clk);
    g_vld = resp_valid; g_err = resp_err; g_dat = resp_rdata;
    req_valid = 1'b0; cap_valid = 1'b0;
  endtask

  task automatic chk(input string tag, input logic exp_err, input logic [31:0] exp_dat);
    n_run++;
    if (g_vld !== 1'b1 || g_err !== exp_err || g_dat !== exp_dat) begin
      n_fail++;
      $display("FAIL %s: got vld=%0b err=%0b data=%h, expected vld=1 err=%0b data=%h",
               tag, g_vld, g_err, g_dat, exp_err, exp_dat);
    end
  endtask

  task automatic rd(input int mid, input int idx, input int fld, input int sz);
    xfer(1'b0, mid, idx, fld, sz, 32'd0, 1'b0, 0, 32'd0);
  endtask

  task automatic wr(input int idx, input int fld, input int sz, input logic [31:0] d);
    xfer(1'b1, 0, idx, fld, sz, d, 1'b0, 0, 32'd0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog: got cycle=%0d, expected below 100000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    n_run++;
    if (resp_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 reset: got resp_valid=%0b, expected 0", resp_valid);
    end
    rst = 1'b0;

    // R3 / R8: full word writes everywhere; R2: every field, index and size read back
    for (int f = 0; f < 3; f++)
      for (int i = 0; i < 4; i++) begin
        wr(i, f, 2, pat(f, i));
        chk("R3 word write", 1'b0, 32'd0);
      end
    for (int f = 0; f < 3; f++)
      for (int i = 0; i < 4; i++)
        for (int s = 0; s < 3; s++) begin
          rd(0, i, f, s);
          chk("R2 sized read", 1'b0, msk(pat(f, i), s));
          if (f == 1) begin
            rd(0, i, 2, 2);  // release the slot taken by the control read
            chk("R4 release after sweep", 1'b0, pat(2, i));
          end
        end
    // R1: idle cycle gives no response
    @(negedge clk);
    n_run++;
    if (resp_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 idle: got resp_valid=%0b, expected 0", resp_valid);
    end

    // R2 / R12: illegal codes
    rd(0, 1, 3, 2);  chk("R2 R12 field code 3", 1'b1, 32'd0);
    rd(0, 1, 0, 3);  chk("R2 R12 size code 3", 1'b1, 32'd0);

    // R3: narrow writes refused, storage unchanged
    wr(0, 2, 0, 32'hFFFF_FFFF); chk("R3 byte write err", 1'b1, 32'd0);
    wr(0, 0, 1, 32'hFFFF_FFFF); chk("R3 half write err", 1'b1, 32'd0);
    rd(0, 0, 2, 2); chk("R3 data unchanged", 1'b0, pat(2, 0));
    rd(0, 0, 0, 2); chk("R3 prog unchanged", 1'b0, pat(0, 0));

    // R4: snapshot survives a later write
    rd(0, 1, 1, 2); chk("R4 ctl read", 1'b0, pat(1, 1));
    wr(1, 2, 2, 32'h0000_1111); chk("R8 write", 1'b0, 32'd0);
    rd(0, 1, 2, 2); chk("R4 shadow data", 1'b0, pat(2, 1));
    rd(0, 1, 2, 2); chk("R4 direct after release", 1'b0, 32'h0000_1111);

    // R6 / R7 / R8: three masters interleave, fourth refused
    rd(0, 0, 1, 2); chk("R6 m0 ctl", 1'b0, pat(1, 0));
    rd(1, 1, 1, 2); chk("R6 m1 ctl", 1'b0, pat(1, 1));
    rd(2, 2, 1, 2); chk("R6 m2 ctl", 1'b0, pat(1, 2));
    rd(3, 3, 1, 2); chk("R7 m3 ctl refused", 1'b1, 32'd0);
    rd(3, 3, 2, 2); chk("R7 m3 data refused", 1'b1, 32'd0);
    rd(3, 3, 0, 2); chk("R8 m3 prog read", 1'b0, pat(0, 3));
    xfer(1'b1, 3, 3, 0, 2, 32'h0BAD_F00D, 1'b0, 0, 32'd0); chk("R8 m3 write", 1'b0, 32'd0);
    rd(3, 3, 0, 2); chk("R8 m3 readback", 1'b0, 32'h0BAD_F00D);
    rd(1, 1, 2, 2); chk("R6 m1 data", 1'b0, 32'h0000_1111);
    rd(0, 0, 2, 2); chk("R6 m0 data", 1'b0, pat(2, 0));
    rd(2, 2, 2, 2); chk("R6 m2 data", 1'b0, pat(2, 2));
    rd(3, 3, 1, 2); chk("R6 m3 ctl after free", 1'b0, pat(1, 3));
    rd(3, 3, 2, 2); chk("R6 m3 data", 1'b0, pat(2, 3));

    // R5: repeated control read by one master reuses its slot
    rd(0, 0, 1, 2); chk("R5 m0 first ctl", 1'b0, pat(1, 0));
    rd(0, 1, 1, 2); chk("R5 m0 second ctl", 1'b0, pat(1, 1));
    rd(1, 2, 1, 2); chk("R5 m1 ctl", 1'b0, pat(1, 2));
    rd(2, 3, 1, 2); chk("R5 m2 ctl", 1'b0, pat(1, 3));
    rd(3, 0, 1, 2); chk("R5 R7 m3 refused", 1'b1, 32'd0);
    rd(0, 0, 2, 2); chk("R5 m0 other index direct", 1'b0, pat(2, 0));
    rd(0, 1, 2, 2); chk("R5 m0 shadow", 1'b0, 32'h0000_1111);
    rd(1, 2, 2, 2); chk("R5 m1 data", 1'b0, pat(2, 2));
    rd(2, 3, 2, 2); chk("R5 m2 data", 1'b0, pat(2, 3));

    // R9: clear after direct read
    wr(2, 1, 2, 32'h0400_0000); chk("R9 set clear bit", 1'b0, 32'd0);
    wr(2, 2, 2, 32'h0000_CAFE);
    rd(1, 2, 2, 2); chk("R9 old value", 1'b0, 32'h0000_CAFE);
    rd(1, 2, 2, 2); chk("R9 cleared", 1'b0, 32'd0);

    // R10: clear after paired read
    wr(2, 2, 2, 32'h0000_BEEF);
    rd(1, 2, 1, 2); chk("R10 ctl", 1'b0, 32'h0400_0000);
    rd(1, 2, 2, 2); chk("R10 shadow value", 1'b0, 32'h0000_BEEF);
    rd(1, 2, 2, 2); chk("R10 cleared", 1'b0, 32'd0);

    // R11: capture beats clear on same word, does not block clear elsewhere
    wr(2, 2, 2, 32'h0000_1234);
    xfer(1'b0, 1, 2, 2, 2, 32'd0, 1'b1, 2, 32'h0000_5678); chk("R11 old value", 1'b0, 32'h0000_1234);
    rd(1, 2, 2, 2); chk("R11 capture kept", 1'b0, 32'h0000_5678);
    rd(1, 2, 2, 2); chk("R11 clear resumes", 1'b0, 32'd0);
    wr(2, 2, 2, 32'h0000_0009);
    xfer(1'b0, 1, 2, 2, 2, 32'd0, 1'b1, 0, 32'h0000_0077); chk("R11 read other", 1'b0, 32'h0000_0009);
    rd(1, 2, 2, 2); chk("R11 cleared alongside capture", 1'b0, 32'd0);
    rd(1, 0, 2, 2); chk("R11 capture other index", 1'b0, 32'h0000_0077);

    // R7: refused data read leaves a clear-enabled word intact
    wr(2, 2, 2, 32'h0000_0042);
    rd(0, 0, 1, 2); rd(1, 0, 1, 2); rd(2, 0, 1, 2);
    rd(3, 2, 2, 2); chk("R7 refused", 1'b1, 32'd0);
    rd(0, 0, 2, 2); rd(1, 0, 2, 2); rd(2, 0, 2, 2);
    rd(3, 2, 2, 0); chk("R7 R2 no clear happened", 1'b0, 32'h0000_0042);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule